// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block produces the bus timing that an 8-bit controller core uses to reach external program and data memory. The low address/data port is shared between address and data. The sequencer runs from the oscillator clock. It divides that clock into machine cycles of 12 clocks, which are 6 states of 2 phases each. From the cycle position it decodes the address-latch strobe, the program-store strobe and the read and write strobes. It also drives the high port with the upper address byte or with the core's port register, and returns fetched bytes and read data to the core.

Every machine cycle is either a fetch cycle or a data cycle. The core holds a request together with its address, width, direction and write data. The sequencer samples that request on the last clock of a fetch cycle and runs the access in the following machine cycle. During a data cycle the second address-latch pulse and both program-store activations are dropped. A select input, latched while reset is in effect, decides whether low program addresses are served internally. A reset pin is honoured only once it has been held for two whole machine cycles.

Top module: `xbus_seq`

## Requirements
- R1: In a fetch cycle `ale` is high for exactly one clock at cycle clock 0 and one clock at cycle clock 6, so it pulses once every 6 clocks. Cycle clocks are numbered 0 to 11, and clock 0 is the first clock after reset is released.
- R2: In a data cycle `ale` is high at clock 0 only. The clock-6 pulse is omitted.
- R3: In a fetch cycle with an external fetch, `psen_n` is low during clocks 2 to 5 and 8 to 11. These are two activations per machine cycle.
- R4: `psen_n` stays high for the whole of every data cycle and of every fetch cycle served internally.
- R5: `ea_pin` is captured while reset is in effect. If it was high, a fetch is internal for `pc` below 16384 (0x4000) and external at or above it. If it was low, every fetch is external.
- R6: In an external fetch cycle, `p0_out` carries `pc[7:0]` with `p0_oe`=1 during clocks 0, 1, 6 and 7, and `p0_oe`=0 otherwise. `p0_in` is sampled on the edges ending clocks 5 and 11, and `fetch_valid` pulses with that byte during the next clock (clock 6 or clock 0). An internal fetch leaves `p0_oe`=0.
- R7: In a write data cycle, `wr_n` is low during clocks 6 to 11. `p0_out` carries the address low byte in clocks 0 and 1 and the write byte from clock 2 to clock 11, with `p0_oe`=1 throughout.
- R8: In a read data cycle, `rd_n` is low during clocks 6 to 11 and `p0_oe` is 0 from clock 2 onward. `p0_in` is sampled on the edge ending clock 11. `acc_done` is high for one clock at clock 0 of the next cycle, with `acc_rdata` holding that byte.
- R9: `p2_out` carries `pc[15:8]` in an external fetch cycle. In a data cycle it carries `req_addr[15:8]` when `req_wide`=1 and `p2_sfr` when `req_wide`=0. It carries `p2_sfr` in an internal fetch cycle.
- R10: A request held on `req_valid` through clock 11 of a fetch cycle turns the next machine cycle into a data cycle for that request.
- R11: `core_rst` rises only after `rst_pin` has been high for 24 consecutive clock edges, and while it is high all strobes are inactive and `p0_oe`=0. A shorter pulse has no effect on the cycle sequence. After `rst_pin` falls, `core_rst` drops on the next edge and cycle clock 0 follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_pin | input | 1 | Raw reset request, active high |
| ea_pin | input | 1 | External-access select, captured during reset |
| pc | input | 16 | Program counter of the core |
| p2_sfr | input | 8 | Core's high-port output register |
| req_valid | input | 1 | Data access request held by the core |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| req_addr | input | 16 | Data address |
| req_wdata | input | 8 | Write byte |
| p0_in | input | 8 | Value read from the low port pads |
| core_rst | output | 1 | Qualified reset for the core |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Low port drive value |
| p0_oe | output | 1 | Low port drive enable |
| p2_out | output | 8 | High port value |
| fetch_valid | output | 1 | Fetched byte valid pulse |
| fetch_data | output | 8 | Fetched byte |
| acc_done | output | 1 | Data access complete pulse |
| acc_rdata | output | 8 | Byte returned by a read |

## Verification
The stimulus covers several kinds of cycle. Internal fetches sit just below the 0x4000 boundary and external fetches sit exactly on it, which separates the two sides of the comparison from an off-by-one. Fetches with the select low show that the latched select, not the address, makes every fetch external. Reads and writes with both address widths show whether the high port picks the address byte or the port register, and whether the low port is released or held. A reset pulse one clock short of the qualifying length is checked against one of exactly the qualifying length. That pair shows whether the qualifier counts the full two machine cycles.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Address-latch pulse slots: first clock of each half cycle, the second one
  // is dropped while a data cycle runs.
  function automatic logic ale_slot(input int unsigned k, input int unsigned half,
                                    input logic dcyc);
    return (k == 0) || ((k == half) && !dcyc);
  endfunction

  // Program-store active window: every clock of a half cycle except its first state.
  function automatic logic psen_slot(input int unsigned k, input int unsigned half,
                                     input int unsigned ph);
    return (k % half) >= ph;
  endfunction

  // Address drive window on the low port: the first state of each half cycle.
  function automatic logic addr_slot(input int unsigned k, input int unsigned half,
                                     input int unsigned ph);
    return (k % half) < ph;
  endfunction

  // Fetch goes external when the select was low or the PC is past internal memory.
  function automatic logic ext_fetch(input logic ea_l, input int unsigned pcv,
                                     input int unsigned limit);
    return !ea_l || (pcv >= limit);
  endfunction

endpackage

// File: rtl/xbus_rst_qual.sv
module xbus_rst_qual #(
  parameter int CLKS = 24
) (
  input  logic clk,
  input  logic rst_pin,
  output logic int_rst,
  output logic armed
);
  localparam int RW = $clog2(CLKS + 1);

  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_pin)               run <= '0;
    else if (run != RW'(CLKS))  run <= run + 1'b1;
  end

  assign int_rst = (run == RW'(CLKS));

  always_ff @(posedge clk) begin
    if (int_rst) armed <= 1'b1;
  end

  AST_RST_HELD: assert property (@(posedge clk) $rose(int_rst) |-> $past(rst_pin)); // R11
  AST_RST_DROP: assert property (@(posedge clk) (int_rst && !rst_pin) |=> !int_rst); // R11

endmodule

// File: rtl/xbus_phase.sv
module xbus_phase #(
  parameter int CYC = 12
) (
  input  logic                    clk,
  input  logic                    int_rst,
  output logic [$clog2(CYC)-1:0]  cnt,
  output logic                    cyc_end
);
  localparam int CW = $clog2(CYC);

  assign cyc_end = (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (int_rst || cyc_end) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/xbus_port_mux.sv
module xbus_port_mux
  import xbus_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int CYC    = 12,
  parameter int PHASES = 2
) (
  input  logic                   int_rst,
  input  logic [$clog2(CYC)-1:0] cnt,
  input  logic                   data_cyc,
  input  logic                   ext,
  input  logic                   d_write,
  input  logic                   d_wide,
  input  logic [AW-1:0]          d_addr,
  input  logic [DW-1:0]          d_wdata,
  input  logic [AW-1:0]          pc,
  input  logic [AW-DW-1:0]       p2_sfr,
  output logic [DW-1:0]          p0_out,
  output logic                   p0_oe,
  output logic [AW-DW-1:0]       p2_out
);
  localparam int HALF = CYC / 2;

  logic in_addr_slot;
  assign in_addr_slot = addr_slot(32'(cnt), HALF, PHASES);

  always_comb begin
    p0_out = '0;
    p0_oe  = 1'b0;
    p2_out = p2_sfr;
    if (!int_rst) begin
      if (data_cyc) begin
        p2_out = d_wide ? d_addr[AW-1:DW] : p2_sfr;
        if (32'(cnt) < PHASES) begin
          p0_out = d_addr[DW-1:0];
          p0_oe  = 1'b1;
        end else if (d_write) begin
          p0_out = d_wdata;
          p0_oe  = 1'b1;
        end
      end else if (ext) begin
        p2_out = pc[AW-1:DW];
        if (in_addr_slot) begin
          p0_out = pc[DW-1:0];
          p0_oe  = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int STATES    = 6,
  parameter int PHASES    = 2,
  parameter int RST_MCYC  = 2,
  parameter int INT_LIMIT = 16384
) (
  input  logic             clk,
  input  logic             rst_pin,
  input  logic             ea_pin,
  input  logic [AW-1:0]    pc,
  input  logic [AW-DW-1:0] p2_sfr,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_wide,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [DW-1:0]    p0_in,
  output logic             core_rst,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    p0_out,
  output logic             p0_oe,
  output logic [AW-DW-1:0] p2_out,
  output logic             fetch_valid,
  output logic [DW-1:0]    fetch_data,
  output logic             acc_done,
  output logic [DW-1:0]    acc_rdata
);
  localparam int CYC      = STATES * PHASES;
  localparam int HALF     = CYC / 2;
  localparam int CW       = $clog2(CYC);
  localparam int RST_CLKS = RST_MCYC * CYC;

  logic          int_rst, armed;
  logic [CW-1:0] cnt;
  logic          cyc_end;
  logic          data_cyc, d_write, d_wide;
  logic [AW-1:0] d_addr;
  logic [DW-1:0] d_wdata;
  logic          ea_lat;
  logic          ext_now;
  logic          fetch_sample;
  logic          ale_w, psen_w, rd_w, wr_w;

  xbus_rst_qual #(.CLKS(RST_CLKS)) u_rst (
    .clk(clk), .rst_pin(rst_pin), .int_rst(int_rst), .armed(armed)
  );

  xbus_phase #(.CYC(CYC)) u_phase (
    .clk(clk), .int_rst(int_rst), .cnt(cnt), .cyc_end(cyc_end)
  );

  assign core_rst = int_rst;

  always_ff @(posedge clk) begin
    if (int_rst) ea_lat <= ea_pin;
  end

  assign ext_now      = ext_fetch(ea_lat, 32'(pc), INT_LIMIT);
  assign fetch_sample = (32'(cnt) == HALF - 1) || cyc_end;

  // Cycle kind and completion pulses
  always_ff @(posedge clk) begin
    if (int_rst) begin
      data_cyc    <= 1'b0;
      acc_done    <= 1'b0;
      fetch_valid <= 1'b0;
    end else begin
      acc_done    <= 1'b0;
      fetch_valid <= !data_cyc && ext_now && fetch_sample;
      if (cyc_end) begin
        if (data_cyc) begin
          data_cyc <= 1'b0;
          acc_done <= 1'b1;
        end else begin
          data_cyc <= req_valid;
        end
      end
    end
  end

  // Captured request fields and returned bytes
  always_ff @(posedge clk) begin
    if (!int_rst && cyc_end && !data_cyc && req_valid) begin
      d_write <= req_write;
      d_wide  <= req_wide;
      d_addr  <= req_addr;
      d_wdata <= req_wdata;
    end
    if (!int_rst && cyc_end && data_cyc && !d_write) acc_rdata <= p0_in;
    if (!int_rst && !data_cyc && ext_now && fetch_sample) fetch_data <= p0_in;
  end

  // Strobe decode
  assign ale_w  = !int_rst && ale_slot(32'(cnt), HALF, data_cyc);
  assign psen_w = !int_rst && !data_cyc && ext_now && psen_slot(32'(cnt), HALF, PHASES);
  assign rd_w   = !int_rst && data_cyc && !d_write && (32'(cnt) >= HALF);
  assign wr_w   = !int_rst && data_cyc &&  d_write && (32'(cnt) >= HALF);

  assign ale    = ale_w;
  assign psen_n = !psen_w;
  assign rd_n   = !rd_w;
  assign wr_n   = !wr_w;

  xbus_port_mux #(.AW(AW), .DW(DW), .CYC(CYC), .PHASES(PHASES)) u_mux (
    .int_rst(int_rst), .cnt(cnt), .data_cyc(data_cyc), .ext(ext_now),
    .d_write(d_write), .d_wide(d_wide), .d_addr(d_addr), .d_wdata(d_wdata),
    .pc(pc), .p2_sfr(p2_sfr), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
  );

  AST_ALE_SINGLE:   assert property (@(posedge clk) disable iff (int_rst || !armed) ale |=> !ale); // R1
  AST_NO_ALE_STRB:  assert property (@(posedge clk) disable iff (int_rst || !armed) (rd_w || wr_w) |-> !ale); // R2
  AST_STRB_NO_PSEN: assert property (@(posedge clk) disable iff (int_rst || !armed) (rd_w || wr_w) |-> psen_n); // R4
  AST_FETCH_AFTER:  assert property (@(posedge clk) disable iff (int_rst || !armed) fetch_valid |-> $past(psen_w)); // R6
  AST_WRITE_HOLD:   assert property (@(posedge clk) disable iff (int_rst || !armed) (wr_w && $past(wr_w)) |-> ($stable(p0_out) && p0_oe)); // R7
  AST_READ_FREE:    assert property (@(posedge clk) disable iff (int_rst || !armed) rd_w |-> !p0_oe); // R8
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (int_rst || !armed) acc_done |=> !acc_done); // R8

endmodule

// File: tb/xbus_seq_tb_top.sv
module xbus_seq_tb_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_pin = 1'b1, ea_pin = 1'b1;
  logic [15:0] pc = '0;
  logic [7:0]  p2_sfr = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, p0_in = '0;
  logic        core_rst, ale, psen_n, rd_n, wr_n, p0_oe, fetch_valid, acc_done;
  logic [7:0]  p0_out, p2_out, fetch_data, acc_rdata;

  xbus_seq dut_i (
    .clk(clk), .rst_pin(rst_pin), .ea_pin(ea_pin), .pc(pc), .p2_sfr(p2_sfr),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .p0_in(p0_in),
    .core_rst(core_rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .acc_done(acc_done), .acc_rdata(acc_rdata)
  );

  typedef struct packed {
    logic        ea;
    logic [15:0] pc;
    logic [7:0]  sfr;
    logic        req;
    logic        wr;
    logic        wide;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  din;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0100, 8'h11, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h21},
    '{1'b1, 16'h3FFF, 8'h12, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h22},
    '{1'b1, 16'h4000, 8'h13, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h23},
    '{1'b1, 16'h4000, 8'h14, 1'b1, 1'b0, 1'b1, 16'h1234, 8'h00, 8'h5A},
    '{1'b1, 16'h0200, 8'h9E, 1'b1, 1'b1, 1'b0, 16'h0077, 8'hC3, 8'h24},
    '{1'b0, 16'h0010, 8'h15, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h00, 8'h25},
    '{1'b0, 16'h0011, 8'h42, 1'b1, 1'b0, 1'b0, 16'h00F0, 8'h00, 8'hA5},
    '{1'b0, 16'hFFFF, 8'h16, 1'b1, 1'b1, 1'b1, 16'hBEEF, 8'h3C, 8'h26}
  };

  int   checks = 0, errors = 0;
  bit   finished = 1'b0;
  logic ea_cur = 1'b1;
  bit   prev_fv = 1'b0, prev_done = 1'b0, prev_rd = 1'b0;
  logic [7:0] prev_din = '0, prev_rdat = '0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Enter at a negedge, leave at the negedge following the edge that releases reset.
  task automatic do_reset(input logic ea);
    ea_pin    = ea;
    req_valid = 1'b0;
    rst_pin   = 1'b1;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R11 core_rst held", 16'(core_rst), 16'd1);
    chk("R11 idle strobes", {12'd0, ale, psen_n, rd_n, wr_n}, 16'b0111);
    chk("R11 port released", 16'(p0_oe), 16'd0);
    rst_pin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 core_rst release", 16'(core_rst), 16'd0);
    ea_cur    = ea;
    prev_fv   = 1'b0;
    prev_done = 1'b0;
    prev_rd   = 1'b0;
  endtask

  // Enter at the negedge of cycle clock 0; leave at the next clock 0.
  task automatic run_cycle(input vec_t v, input bit dcyc);
    logic ext;
    ext = !ea_cur || (v.pc >= 16'h4000);
    for (int k = 0; k < 12; k++) begin
      if (k == 0) begin
        pc        = v.pc;
        p2_sfr    = v.sfr;
        p0_in     = v.din;
        req_valid = !dcyc && v.req;
        req_write = v.wr;
        req_wide  = v.wide;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        #1;
      end
      begin
        logic e_ale, e_psen, e_rd, e_wr, e_oe, e_fv;
        logic [7:0] e_p0, e_p2, e_fd;
        e_ale  = (k == 0) || (k == 6 && !dcyc);
        e_psen = !(!dcyc && ext && (k % 6) >= 2);
        e_rd   = !(dcyc && !v.wr && k >= 6);
        e_wr   = !(dcyc &&  v.wr && k >= 6);
        e_oe   = dcyc ? (k < 2 || v.wr) : (ext && (k % 6) < 2);
        e_p0   = dcyc ? ((k < 2) ? v.addr[7:0] : v.wdata) : v.pc[7:0];
        e_p2   = dcyc ? (v.wide ? v.addr[15:8] : v.sfr) : (ext ? v.pc[15:8] : v.sfr);
        e_fv   = (k == 0) ? prev_fv : ((k == 6) ? (!dcyc && ext) : 1'b0);
        e_fd   = (k == 0) ? prev_din : v.din;

        chk(dcyc ? "R2 ale" : "R1 ale", 16'(ale), 16'(e_ale));
        chk(dcyc ? "R4 psen data" : (ext ? "R3 psen" : "R4 psen internal"),
            16'(psen_n), 16'(e_psen));
        if (!dcyc && k == 2) chk("R5 fetch side", 16'(psen_n), 16'(!ext));
        chk("R8 rd_n", 16'(rd_n), 16'(e_rd));
        chk("R7 wr_n", 16'(wr_n), 16'(e_wr));
        chk(dcyc ? (v.wr ? "R7 oe" : "R8 oe") : "R6 oe", 16'(p0_oe), 16'(e_oe));
        if (e_oe) chk(dcyc ? (v.wr ? "R7 p0" : "R8 p0") : "R6 p0", 16'(p0_out), 16'(e_p0));
        if (dcyc && k == 0) chk("R10 data address", 16'(p0_out), 16'(v.addr[7:0]));
        chk("R9 p2", 16'(p2_out), 16'(e_p2));
        chk("R6 fetch_valid", 16'(fetch_valid), 16'(e_fv));
        if (e_fv) chk("R6 fetch_data", 16'(fetch_data), 16'(e_fd));
        if (k == 0) begin
          chk("R8 acc_done", 16'(acc_done), 16'(prev_done));
          if (prev_done && prev_rd) chk("R8 acc_rdata", 16'(acc_rdata), 16'(prev_rdat));
        end else if (k == 1) begin
          chk("R8 acc_done pulse", 16'(acc_done), 16'd0);
        end
      end
      @(posedge clk);
      @(negedge clk);
    end
    prev_fv   = !dcyc && ext;
    prev_din  = v.din;
    prev_done = dcyc;
    prev_rd   = dcyc && !v.wr;
    prev_rdat = v.din;
  endtask

  initial begin
    vec_t idle;
    @(negedge clk);
    do_reset(1'b1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].ea != ea_cur) do_reset(VECS[i].ea);
      run_cycle(VECS[i], 1'b0);
      if (VECS[i].req) run_cycle(VECS[i], 1'b1);
    end
    idle     = VECS[0];
    idle.req = 1'b0;
    run_cycle(idle, 1'b0);

    // R11: a 23-clock pulse leaves the cycle sequence running
    rst_pin = 1'b1;
    for (int i = 1; i <= 23; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 short pulse core_rst", 16'(core_rst), 16'd0);
      chk("R11 short pulse ale", 16'(ale), 16'(((i % 12) % 6) == 0));
    end
    rst_pin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 short pulse next ale", 16'(ale), 16'd1);

    // R11: a 24-clock pulse resets, and clock 0 follows the release
    rst_pin = 1'b1;
    for (int i = 1; i <= 24; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 full pulse core_rst", 16'(core_rst), 16'(i == 24));
    end
    chk("R11 reset ale idle", 16'(ale), 16'd0);
    rst_pin = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11 restart core_rst", 16'(core_rst), 16'd0);
    chk("R11 restart ale", 16'(ale), 16'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R11 restart ale low", 16'(ale), 16'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule